// File: doc/BRIEF.md
# Prescaled Reload Time-Base Timer

This block is a free-running time base. A 16-bit counter climbs by one on every prescaled tick. When it reaches a programmable reload value, it returns to zero, and that wrap is the update event. The tick rate comes from a 16-bit divider, which gives a ratio of the divider register plus one. The divider value in use, and optionally the reload value, are shadow copies. Each update event refreshes them, so a new period never takes effect in the middle of a period.

Software reaches the timer through a single-cycle register port. Writes take effect at the clock edge, and reads return data combinationally. Software can force an update event, block update events entirely, or keep forced updates silent. It can also make the counter stop after one period. Every update produces three outputs:
- a level interrupt request, taken from a sticky flag;
- a one-cycle DMA request pulse;
- a selectable trigger output for a downstream converter.

The counter, divider and reload registers stay readable and writable while the counter runs.

Top module: `tick_timer`

## Requirements
- R1: After reset, every register reads 0, and `upd_irq`, `upd_dma` and `trg_out` are low.
- R2: While CTRL bit 0 (run) is set, the counter (COUNT, byte offset 0x14) advances once every divider-active+1 clocks. On a tick at which it equals the active reload value, it goes to 0 instead. When run is clear, the counter holds.
- R3: A write to DIV (offset 0x18) changes the division ratio only from the next update event.
- R4: With CTRL bit 4 set, a RELOAD (offset 0x1C) write is held until the next update event. With bit 4 clear, it is used at once.
- R5: Writing 1 to EVGEN (offset 0x10) bit 0 forces an update event. This zeroes the counter and the prescaler and loads both shadow copies.
- R6: With CTRL bit 1 set, no update event occurs: the counter still wraps, but the flag, the shadow copies and the outputs are untouched, and EVGEN writes have no effect.
- R7: With CTRL bit 2 set, a forced update loads the shadow copies but sets no flag and raises no DMA pulse. Wraps still do both.
- R8: With CTRL bit 3 set, the run bit clears itself at the update event, leaving the counter at 0.
- R9: An update event sets FLAG (offset 0x0C) bit 0 at the edge that zeroes the counter. Writing 0 to the bit clears it, writing 1 leaves it unchanged, and a set in the same cycle wins over a clear.
- R10: `upd_irq` is high while the flag is set and IEN (offset 0x08) bit 0 is set. `upd_dma` pulses for one cycle per flag-setting update event when IEN bit 1 is set.
- R11: With CTRL bit 5 set, COUNT read data bit 31 shows the flag.
- R12: TRGSEL (offset 0x04) bits 2:0 select `trg_out`, which is registered:
  - 0: a pulse on each accepted forced update;
  - 1: the run bit;
  - 2: a pulse on every update event;
  - any other value: low.
- R13: COUNT, DIV and RELOAD can be read and written while running. A COUNT write overrides counting at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits 4:2 pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| upd_irq | output | 1 | Update interrupt request (level) |
| upd_dma | output | 1 | Update DMA request (one-cycle pulse) |
| trg_out | output | 1 | Selected trigger for a downstream converter |

## Verification
The assertions watch the following every cycle:
- the counter returns to zero after its wrap tick;
- the counter holds while stopped;
- a COUNT write lands;
- the reload shadow freezes while updates are disabled;
- one-shot mode drops the run bit;
- a DMA pulse never appears without the flag;
- clearing the flag drops the interrupt.

Only the bench scenarios can show the values that depend on the prescaler and the shadow timing. These include counts after a given number of clocks under different divider and reload settings, the buffered versus immediate reload, the deferred divider change, the silent forced update, the trigger selections and the flag mirror.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int unsigned REG_AW = 5;

  // word index = byte address bits 4:2
  localparam logic [2:0] IDX_CTRL = 3'd0;
  localparam logic [2:0] IDX_TRG  = 3'd1;
  localparam logic [2:0] IDX_IEN  = 3'd2;
  localparam logic [2:0] IDX_FLAG = 3'd3;
  localparam logic [2:0] IDX_EVG  = 3'd4;
  localparam logic [2:0] IDX_CNT  = 3'd5;
  localparam logic [2:0] IDX_DIV  = 3'd6;
  localparam logic [2:0] IDX_RLD  = 3'd7;

  // control bit positions
  localparam int unsigned B_RUN  = 0;
  localparam int unsigned B_OFF  = 1;
  localparam int unsigned B_OVF  = 2;
  localparam int unsigned B_ONE  = 3;
  localparam int unsigned B_BUF  = 4;
  localparam int unsigned B_MIR  = 5;

  // enable bit positions
  localparam int unsigned B_IRQ  = 0;
  localparam int unsigned B_DMA  = 1;

  // trigger selections
  localparam logic [2:0] TRG_SWUPD = 3'd0;
  localparam logic [2:0] TRG_RUN   = 3'd1;
  localparam logic [2:0] TRG_UPD   = 3'd2;

  typedef struct packed {
    logic mirror;
    logic buffered;
    logic single;
    logic ovf_only;
    logic upd_off;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned PW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en,
  input  logic          acc_wr,
  input  logic [2:0]    acc_idx,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] acc_rdata,
  input  logic [CW-1:0] cnt,
  input  logic          stop_req,
  input  logic          upd_req,
  output ctrl_t         ctrl,
  output logic [2:0]    trg_sel,
  output logic          irq_en,
  output logic          dma_en,
  output logic [PW-1:0] div_reg,
  output logic [CW-1:0] rld_reg,
  output logic          flag,
  output logic          ug_pulse,
  output logic          cnt_wr,
  output logic [CW-1:0] cnt_wdata
);

  localparam int unsigned TOP_BIT = DW - 1;

  ctrl_t         ctrl_q, ctrl_d;
  logic [2:0]    trg_q, trg_d;
  logic          irq_q, irq_d, dma_q, dma_d;
  logic [PW-1:0] div_q, div_d;
  logic [CW-1:0] rld_q, rld_d;
  logic          flag_q, flag_d;

  logic wr_ctrl, wr_trg, wr_ien, wr_flag, wr_div, wr_rld;

  always_comb begin
    wr_ctrl  = acc_en && acc_wr && (acc_idx == IDX_CTRL);
    wr_trg   = acc_en && acc_wr && (acc_idx == IDX_TRG);
    wr_ien   = acc_en && acc_wr && (acc_idx == IDX_IEN);
    wr_flag  = acc_en && acc_wr && (acc_idx == IDX_FLAG);
    wr_div   = acc_en && acc_wr && (acc_idx == IDX_DIV);
    wr_rld   = acc_en && acc_wr && (acc_idx == IDX_RLD);
    ug_pulse = acc_en && acc_wr && (acc_idx == IDX_EVG) && acc_wdata[0];
    cnt_wr   = acc_en && acc_wr && (acc_idx == IDX_CNT);
    cnt_wdata = acc_wdata[CW-1:0];
  end

  // next state
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.run      = acc_wdata[B_RUN];
      ctrl_d.upd_off  = acc_wdata[B_OFF];
      ctrl_d.ovf_only = acc_wdata[B_OVF];
      ctrl_d.single   = acc_wdata[B_ONE];
      ctrl_d.buffered = acc_wdata[B_BUF];
      ctrl_d.mirror   = acc_wdata[B_MIR];
    end
    if (stop_req) ctrl_d.run = 1'b0;

    trg_d = wr_trg ? acc_wdata[2:0] : trg_q;
    irq_d = wr_ien ? acc_wdata[B_IRQ] : irq_q;
    dma_d = wr_ien ? acc_wdata[B_DMA] : dma_q;
    div_d = wr_div ? acc_wdata[PW-1:0] : div_q;
    rld_d = wr_rld ? acc_wdata[CW-1:0] : rld_q;

    flag_d = flag_q;
    if (wr_flag && !acc_wdata[0]) flag_d = 1'b0;
    if (upd_req) flag_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      trg_q  <= '0;
      irq_q  <= 1'b0;
      dma_q  <= 1'b0;
      div_q  <= '0;
      rld_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      trg_q  <= trg_d;
      irq_q  <= irq_d;
      dma_q  <= dma_d;
      div_q  <= div_d;
      rld_q  <= rld_d;
      flag_q <= flag_d;
    end
  end

  // read mux
  always_comb begin
    acc_rdata = '0;
    unique case (acc_idx)
      IDX_CTRL: begin
        acc_rdata[B_RUN] = ctrl_q.run;
        acc_rdata[B_OFF] = ctrl_q.upd_off;
        acc_rdata[B_OVF] = ctrl_q.ovf_only;
        acc_rdata[B_ONE] = ctrl_q.single;
        acc_rdata[B_BUF] = ctrl_q.buffered;
        acc_rdata[B_MIR] = ctrl_q.mirror;
      end
      IDX_TRG:  acc_rdata[2:0] = trg_q;
      IDX_IEN: begin
        acc_rdata[B_IRQ] = irq_q;
        acc_rdata[B_DMA] = dma_q;
      end
      IDX_FLAG: acc_rdata[0] = flag_q;
      IDX_EVG:  acc_rdata = '0;
      IDX_CNT: begin
        acc_rdata[CW-1:0] = cnt;
        acc_rdata[TOP_BIT] = ctrl_q.mirror && flag_q;
      end
      IDX_DIV:  acc_rdata[PW-1:0] = div_q;
      IDX_RLD:  acc_rdata[CW-1:0] = rld_q;
      default:  acc_rdata = '0;
    endcase
  end

  assign ctrl    = ctrl_q;
  assign trg_sel = trg_q;
  assign irq_en  = irq_q;
  assign dma_en  = dma_q;
  assign div_reg = div_q;
  assign rld_reg = rld_q;
  assign flag    = flag_q;

endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core
  import tick_timer_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_t         ctrl,
  input  logic [PW-1:0] div_reg,
  input  logic [CW-1:0] rld_reg,
  input  logic          ug_pulse,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] rld_act,
  output logic          wrap,
  output logic          sw_upd,
  output logic          upd_evt,
  output logic          upd_req,
  output logic          stop_req
);

  logic [PW-1:0] pcnt_q, pcnt_d;
  logic [PW-1:0] div_act_q, div_act_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] rld_act_q, rld_act_d;
  logic [CW-1:0] rld_eff;
  logic          tick;

  always_comb begin
    rld_eff  = ctrl.buffered ? rld_act_q : rld_reg;
    tick     = ctrl.run && (pcnt_q == div_act_q);
    wrap     = tick && (cnt_q == rld_eff);
    sw_upd   = ug_pulse && !ctrl.upd_off;
    upd_evt  = (wrap && !ctrl.upd_off) || sw_upd;
    upd_req  = upd_evt && (wrap || !ctrl.ovf_only);
    stop_req = upd_evt && ctrl.single;
  end

  // next state
  always_comb begin
    pcnt_d = pcnt_q;
    if (sw_upd)        pcnt_d = '0;
    else if (ctrl.run) pcnt_d = tick ? '0 : pcnt_q + 1'b1;

    cnt_d = cnt_q;
    if (cnt_wr)             cnt_d = cnt_wdata;
    else if (sw_upd || wrap) cnt_d = '0;
    else if (tick)          cnt_d = cnt_q + 1'b1;

    div_act_d = upd_evt ? div_reg : div_act_q;
    rld_act_d = upd_evt ? rld_reg : rld_act_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q    <= '0;
      cnt_q     <= '0;
      div_act_q <= '0;
      rld_act_q <= '0;
    end else begin
      pcnt_q    <= pcnt_d;
      cnt_q     <= cnt_d;
      div_act_q <= div_act_d;
      rld_act_q <= rld_act_d;
    end
  end

  assign cnt     = cnt_q;
  assign rld_act = rld_act_q;

endmodule

// File: rtl/tick_timer_out.sv
module tick_timer_out
  import tick_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] trg_sel,
  input  logic       run,
  input  logic       sw_upd,
  input  logic       upd_evt,
  input  logic       upd_req,
  input  logic       dma_en,
  output logic       dma_pulse,
  output logic       trg
);

  logic dma_q, dma_d, trg_q, trg_d;

  always_comb begin
    dma_d = upd_req && dma_en;
    unique case (trg_sel)
      TRG_SWUPD: trg_d = sw_upd;
      TRG_RUN:   trg_d = run;
      TRG_UPD:   trg_d = upd_evt;
      default:   trg_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_q <= 1'b0;
      trg_q <= 1'b0;
    end else begin
      dma_q <= dma_d;
      trg_q <= trg_d;
    end
  end

  assign dma_pulse = dma_q;
  assign trg       = trg_q;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PSC_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              upd_irq,
  output logic              upd_dma,
  output logic              trg_out
);

  // reset asserted asynchronously, released on the clock
  logic rst_m1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_m1     <= 1'b1;
      rst_sync_n <= rst_m1;
    end
  end

  ctrl_t             ctrl;
  logic [2:0]        trg_sel;
  logic              irq_en, dma_en, flag;
  logic [PSC_W-1:0]  div_reg;
  logic [CNT_W-1:0]  rld_reg, rld_act, cnt, cnt_wdata;
  logic              ug_pulse, cnt_wr;
  logic              wrap, sw_upd, upd_evt, upd_req, stop_req;

  tick_timer_regs #(.CW(CNT_W), .PW(PSC_W), .DW(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .acc_en    (bus_sel),
    .acc_wr    (bus_wr),
    .acc_idx   (bus_addr[4:2]),
    .acc_wdata (bus_wdata),
    .acc_rdata (bus_rdata),
    .cnt       (cnt),
    .stop_req  (stop_req),
    .upd_req   (upd_req),
    .ctrl      (ctrl),
    .trg_sel   (trg_sel),
    .irq_en    (irq_en),
    .dma_en    (dma_en),
    .div_reg   (div_reg),
    .rld_reg   (rld_reg),
    .flag      (flag),
    .ug_pulse  (ug_pulse),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata)
  );

  tick_timer_core #(.CW(CNT_W), .PW(PSC_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ctrl      (ctrl),
    .div_reg   (div_reg),
    .rld_reg   (rld_reg),
    .ug_pulse  (ug_pulse),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .cnt       (cnt),
    .rld_act   (rld_act),
    .wrap      (wrap),
    .sw_upd    (sw_upd),
    .upd_evt   (upd_evt),
    .upd_req   (upd_req),
    .stop_req  (stop_req)
  );

  tick_timer_out u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .trg_sel   (trg_sel),
    .run       (ctrl.run),
    .sw_upd    (sw_upd),
    .upd_evt   (upd_evt),
    .upd_req   (upd_req),
    .dma_en    (dma_en),
    .dma_pulse (upd_dma),
    .trg       (trg_out)
  );

  assign upd_irq = flag && irq_en;

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              single,
  input logic              upd_off,
  input logic              wrap,
  input logic [CW-1:0]     cnt,
  input logic              cnt_wr,
  input logic [CW-1:0]     cnt_wdata,
  input logic              ug_pulse,
  input logic [CW-1:0]     rld_act,
  input logic              upd_req,
  input logic              flag,
  input logic              upd_dma,
  input logic              upd_irq,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [REG_AW-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata
);

  logic flag_clr;
  assign flag_clr = bus_sel && bus_wr && (bus_addr[4:2] == IDX_FLAG) && !bus_wdata[0];

  // R2
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !cnt_wr) |=> (cnt == '0));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr && !ug_pulse) |=> $stable(cnt));

  // R13
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(cnt_wdata)));

  // R6
  no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_off |=> $stable(rld_act));

  // R8
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && single && wrap && !upd_off) |=> !run);

  // R10
  dma_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_dma |-> flag);

  // R9
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !upd_req) |=> !upd_irq);

endmodule

bind tick_timer tick_timer_chk #(.CW(CNT_W), .DW(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .run       (ctrl.run),
  .single    (ctrl.single),
  .upd_off   (ctrl.upd_off),
  .wrap      (wrap),
  .cnt       (cnt),
  .cnt_wr    (cnt_wr),
  .cnt_wdata (cnt_wdata),
  .ug_pulse  (ug_pulse),
  .rld_act   (rld_act),
  .upd_req   (upd_req),
  .flag      (flag),
  .upd_dma   (upd_dma),
  .upd_irq   (upd_irq),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata)
);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;

  localparam int CLK_PERIOD = 10;

  localparam logic [4:0] A_CTRL = 5'h00, A_TRG = 5'h04, A_IEN = 5'h08, A_FLAG = 5'h0C,
                         A_EVG  = 5'h10, A_CNT = 5'h14, A_DIV = 5'h18, A_RLD  = 5'h1C;
  localparam logic [31:0] C_RUN = 32'h01, C_OFF = 32'h02, C_OVF = 32'h04,
                          C_ONE = 32'h08, C_BUF = 32'h10, C_MIR = 32'h20;

  typedef struct packed {
    logic [15:0] dv;
    logic [15:0] rl;
    logic [15:0] n;
    logic [15:0] ecnt;
    logic [15:0] eflag;
  } vec_t;

  // divider, reload, clocks run, expected count, expected flag
  localparam vec_t VECS [5] = '{
    '{16'd0, 16'd9,   16'd5,  16'd5, 16'd0},
    '{16'd0, 16'd4,   16'd7,  16'd2, 16'd1},
    '{16'd2, 16'd100, 16'd10, 16'd3, 16'd0},
    '{16'd1, 16'd2,   16'd13, 16'd0, 16'd1},
    '{16'd3, 16'd0,   16'd9,  16'd0, 16'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        upd_irq, upd_dma, trg_out;

  int checks = 0;
  int fails  = 0;
  int dma_cnt = 0;
  int trg_cnt = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .upd_irq(upd_irq), .upd_dma(upd_dma), .trg_out(trg_out)
  );

  always @(negedge clk) begin
    if (upd_dma) dma_cnt++;
    if (trg_out) trg_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rdr(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  // counts exactly n clock edges with run set (n >= 2)
  task automatic run_for(input logic [31:0] bits, input int n);
    wr(A_CTRL, bits | C_RUN);
    repeat (n - 2) @(negedge clk);
    wr(A_CTRL, bits);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rdr(5'(i * 4), rd);
      chk("R1 register", rd, 32'h0);
    end
    chk("R1 irq", {31'b0, upd_irq}, 0);
    chk("R1 dma", {31'b0, upd_dma}, 0);
    chk("R1 trg", {31'b0, trg_out}, 0);

    // R2 table of prescale / reload patterns
    for (int v = 0; v < 5; v++) begin
      wr(A_CTRL, C_OVF);
      wr(A_DIV, {16'b0, VECS[v].dv});
      wr(A_RLD, {16'b0, VECS[v].rl});
      wr(A_EVG, 32'h1);
      wr(A_FLAG, 32'h0);
      rdr(A_FLAG, rd);
      chk("R7 silent forced update", rd, 32'h0);
      run_for(C_OVF, int'(VECS[v].n));
      rdr(A_CNT, rd);
      chk("R2 count", rd, {16'b0, VECS[v].ecnt});
      rdr(A_FLAG, rd);
      chk("R2 wrap flag", rd, {16'b0, VECS[v].eflag});
    end

    // R3 divider takes effect at update only
    wr(A_CTRL, C_OVF);
    wr(A_DIV, 32'd0);
    wr(A_RLD, 32'd1000);
    wr(A_EVG, 32'h1);
    wr(A_DIV, 32'd3);
    wr(A_CNT, 32'd0);
    run_for(C_OVF, 4);
    rdr(A_CNT, rd);
    chk("R3 old divider", rd, 32'd4);
    wr(A_EVG, 32'h1);
    run_for(C_OVF, 8);
    rdr(A_CNT, rd);
    chk("R3 new divider", rd, 32'd2);

    // R4 buffered reload
    wr(A_DIV, 32'd0);
    wr(A_CTRL, C_OVF | C_BUF);
    wr(A_RLD, 32'd9);
    wr(A_EVG, 32'h1);
    wr(A_CNT, 32'd1);
    wr(A_RLD, 32'd2);
    run_for(C_OVF | C_BUF, 3);
    rdr(A_CNT, rd);
    chk("R4 buffered", rd, 32'd4);
    // R4 immediate reload
    wr(A_CTRL, C_OVF);
    wr(A_CNT, 32'd1);
    run_for(C_OVF, 3);
    rdr(A_CNT, rd);
    chk("R4 immediate", rd, 32'd1);

    // R5 forced update zeroes counter
    wr(A_CNT, 32'd77);
    wr(A_EVG, 32'h1);
    rdr(A_CNT, rd);
    chk("R5 forced zero", rd, 32'd0);

    // R6 updates disabled
    wr(A_CTRL, C_BUF);
    wr(A_RLD, 32'd9);
    wr(A_EVG, 32'h1);
    wr(A_FLAG, 32'h0);
    wr(A_CTRL, C_BUF | C_OFF);
    wr(A_RLD, 32'd2);
    wr(A_CNT, 32'd3);
    wr(A_EVG, 32'h1);
    rdr(A_CNT, rd);
    chk("R6 forced update ignored", rd, 32'd3);
    wr(A_CNT, 32'd0);
    run_for(C_BUF | C_OFF, 12);
    rdr(A_CNT, rd);
    chk("R6 shadow kept", rd, 32'd2);
    rdr(A_FLAG, rd);
    chk("R6 no flag", rd, 32'd0);

    // R7 source filter
    wr(A_CTRL, C_OVF);
    wr(A_IEN, 32'h2);
    dma_cnt = 0;
    wr(A_EVG, 32'h1);
    rdr(A_FLAG, rd);
    chk("R7 flag stays clear", rd, 32'd0);
    chk("R7 no dma", dma_cnt, 0);
    wr(A_CTRL, 32'h0);
    wr(A_EVG, 32'h1);
    rdr(A_FLAG, rd);
    chk("R7 unfiltered flag", rd, 32'd1);
    chk("R7 unfiltered dma", dma_cnt, 1);

    // R9 flag clearing
    wr(A_FLAG, 32'h0);
    rdr(A_FLAG, rd);
    chk("R9 clear", rd, 32'd0);
    wr(A_FLAG, 32'h1);
    rdr(A_FLAG, rd);
    chk("R9 write one no effect", rd, 32'd0);

    // R10 / R12 update outputs
    wr(A_IEN, 32'h3);
    wr(A_TRG, 32'd2);
    wr(A_DIV, 32'd0);
    wr(A_RLD, 32'd3);
    wr(A_EVG, 32'h1);
    wr(A_FLAG, 32'h0);
    wr(A_CNT, 32'd0);
    dma_cnt = 0;
    trg_cnt = 0;
    run_for(32'h0, 10);
    rdr(A_CNT, rd);
    chk("R2 wrap count", rd, 32'd2);
    chk("R10 dma pulses", dma_cnt, 2);
    chk("R12 update trigger pulses", trg_cnt, 2);
    chk("R10 irq set", {31'b0, upd_irq}, 1);
    wr(A_FLAG, 32'h0);
    chk("R10 irq clear", {31'b0, upd_irq}, 0);
    wr(A_IEN, 32'h1);
    wr(A_CNT, 32'd0);
    dma_cnt = 0;
    run_for(32'h0, 10);
    chk("R10 dma disabled", dma_cnt, 0);
    chk("R10 irq enabled", {31'b0, upd_irq}, 1);

    // R11 flag mirror in count read
    wr(A_CTRL, C_MIR);
    rdr(A_CNT, rd);
    chk("R11 mirror set", {31'b0, rd[31]}, 1);
    wr(A_FLAG, 32'h0);
    rdr(A_CNT, rd);
    chk("R11 mirror clear", {31'b0, rd[31]}, 0);

    // R12 other trigger selections
    wr(A_CTRL, 32'h0);
    wr(A_TRG, 32'd0);
    trg_cnt = 0;
    wr(A_EVG, 32'h1);
    repeat (2) @(negedge clk);
    chk("R12 forced update trigger", trg_cnt, 1);
    wr(A_TRG, 32'd1);
    wr(A_CTRL, C_RUN);
    repeat (2) @(negedge clk);
    chk("R12 run level high", {31'b0, trg_out}, 1);
    wr(A_TRG, 32'd5);
    repeat (2) @(negedge clk);
    chk("R12 unused select low", {31'b0, trg_out}, 0);
    wr(A_TRG, 32'd1);
    wr(A_CTRL, 32'h0);
    repeat (2) @(negedge clk);
    chk("R12 run level low", {31'b0, trg_out}, 0);

    // R8 one-shot
    wr(A_RLD, 32'd3);
    wr(A_EVG, 32'h1);
    wr(A_FLAG, 32'h0);
    wr(A_CNT, 32'd0);
    wr(A_CTRL, C_ONE | C_RUN);
    repeat (10) @(negedge clk);
    rdr(A_CTRL, rd);
    chk("R8 run cleared", rd, C_ONE);
    rdr(A_CNT, rd);
    chk("R8 counter parked", rd, 32'd0);
    rdr(A_FLAG, rd);
    chk("R8 flag", rd, 32'd1);

    // R13 access while running
    wr(A_CTRL, C_OVF);
    wr(A_DIV, 32'd0);
    wr(A_RLD, 32'd1000);
    wr(A_EVG, 32'h1);
    wr(A_DIV, 32'h1234);
    wr(A_CTRL, C_OVF | C_RUN);
    wr(A_CNT, 32'd100);
    rdr(A_CNT, rd);
    chk("R13 count write while running", rd, 32'd101);
    wr(A_CTRL, C_OVF);
    rdr(A_DIV, rd);
    chk("R13 divider readback", rd, 32'h1234);
    rdr(A_RLD, rd);
    chk("R13 reload readback", rd, 32'd1000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule